// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block performs the entry half of exception handling once an arbiter has granted an exception. On a grant it does two things at once. It saves eight context words to the current stack through a word-wide write port. It also fetches the handler start address from the vector table through a read port. When both have finished, it sends a single-cycle completion pulse. The pulse carries the handler address for the fetch unit, the link-register return code, the number whose pending bit is to be cleared and active bit set, and the new stack pointer.

A tail-chained grant skips the saving of context. Only the vector is fetched, and the stack pointer is not updated. A higher-priority exception can be reported while an entry is in progress. In that case the vector read restarts for the new number and any result of the old read is discarded. Frame writes already under way run to completion without restarting. The completion pulse then names the newer exception. The earlier exception is never reported, so its pending status stays untouched.

Top module: `exc_entry_seq`

## Requirements
- R1: A grant is taken only while `busy` is low. `busy` rises on the clock edge that takes the grant and falls on the edge that raises `done_valid`.
- R2: For a grant with `grant_tail` low, exactly eight writes are made, in rising address order, starting at `cur_sp - 32` in steps of 4. Write i carries `ctx_frame[32*i +: 32]`. The word order is r0, r1, r2, r3, r12, lr, return pc, status word. The frame and the stack pointer are captured on the grant edge.
- R3: Each port moves at most one word per cycle. A request is accepted on a cycle where its valid and ready are both high. While ready is low, address and data hold steady.
- R4: The vector read is issued at `vec_base + 4*number` on the cycle after the grant, in parallel with the first frame write.
- R5: `done_valid` pulses only after every frame write and the vector read have completed. `done_handler` equals the word returned by the accepted read.
- R6: With the pulse, `sp_load` is high and `sp_value = cur_sp - 32` for a stacked entry. `sp_load` is low for a tail-chained entry.
- R7: A grant with `grant_tail` high makes no writes.
- R8: `done_lr` is 0xFFFFFFF1 when entry came from handler mode (`from_handler` high). Otherwise it is 0xFFFFFFF9 on the main stack (`on_psp` low) and 0xFFFFFFFD on the process stack.
- R9: `done_num` is the number of the exception whose handler starts; its pending bit is cleared and its active bit set.
- R10: `late_valid` while busy restarts the vector read at `vec_base + 4*late_num` on the next cycle and drops any earlier read result. Frame writes continue unchanged, and `done_num` reports `late_num`.
- R11: `late_valid` while idle has no effect: `busy` and `rd_valid` stay low.
- R12: `done_valid` is a single-cycle pulse. It rises one cycle after the cycle in which both the writes and the read are complete and no late arrival is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grant_valid | input | 1 | Arbiter grants an exception |
| grant_num | input | NUM_W | Granted exception number |
| grant_tail | input | 1 | Grant is tail-chained; skip stacking |
| from_handler | input | 1 | Core was in handler mode before entry |
| on_psp | input | 1 | Thread mode was using the process stack |
| cur_sp | input | 32 | Current stack pointer |
| ctx_frame | input | 256 | Eight context words, word i at bits 32*i+31:32*i |
| vec_base | input | 32 | Vector table base address |
| late_valid | input | 1 | Higher-priority exception arrived during entry |
| late_num | input | NUM_W | Number of the late exception |
| busy | output | 1 | Entry in progress |
| wr_valid | output | 1 | Stack write request |
| wr_addr | output | 32 | Stack write byte address |
| wr_data | output | 32 | Stack write data |
| wr_ready | input | 1 | Stack write accepted |
| rd_valid | output | 1 | Vector read request |
| rd_addr | output | 32 | Vector read byte address |
| rd_ready | input | 1 | Vector read accepted, data valid |
| rd_data | input | 32 | Vector read data |
| done_valid | output | 1 | Handler start pulse |
| done_handler | output | 32 | Handler start address |
| done_num | output | NUM_W | Exception to mark active and clear pending |
| done_lr | output | 32 | Return code for the link register |
| sp_load | output | 1 | Load new stack pointer |
| sp_value | output | 32 | New stack pointer value |

## Verification
When both ports are always ready, the completion pulse is due 10 cycles after the grant cycle for a stacked entry and 3 cycles after it for a tail-chained entry. A late arrival reported k cycles after the grant delays the pulse to the later of 10 and k+3 cycles. The tail-chained case with k = 1 gives 4 cycles. The driver pushes this latency, together with the expected fields, into the scoreboard. The monitor samples on falling edges, measures the cycle distance from the recorded grant cycle and compares it. For runs with stalled ports, the latency check is switched off and only the order and contents of writes and completions are compared.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned FRAME_WORDS = 8;
    localparam int unsigned FRAME_BYTES = FRAME_WORDS * (WORD_W / 8);

    localparam logic [WORD_W-1:0] RET_TO_HANDLER     = 32'hFFFF_FFF1;
    localparam logic [WORD_W-1:0] RET_TO_THREAD_MAIN = 32'hFFFF_FFF9;
    localparam logic [WORD_W-1:0] RET_TO_THREAD_PROC = 32'hFFFF_FFFD;

    typedef enum logic [0:0] {
        ENTRY_IDLE = 1'b0,
        ENTRY_RUN  = 1'b1
    } entry_state_e;

    function automatic logic [WORD_W-1:0] return_code(input logic from_handler,
                                                      input logic on_psp);
        if (from_handler) begin
            return RET_TO_HANDLER;
        end else if (on_psp) begin
            return RET_TO_THREAD_PROC;
        end
        return RET_TO_THREAD_MAIN;
    endfunction

endpackage

// File: rtl/exc_frame_writer.sv
`timescale 1ns/1ps
module exc_frame_writer #(
    parameter int unsigned WORDS = 8,
    parameter int unsigned DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              skip,
    input  logic [DW-1:0]     base,
    input  logic [WORDS*DW-1:0] frame,
    output logic              wr_valid,
    output logic [DW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    input  logic              wr_ready,
    output logic              done
);

    localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);
    localparam int unsigned BYTE_SHIFT = $clog2(DW / 8);

    typedef struct packed {
        logic                active;
        logic                done;
        logic [IDX_W-1:0]    idx;
        logic [DW-1:0]       base;
        logic [WORDS*DW-1:0] frame;
    } wr_state_t;

    wr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.base   = base;
            st_d.frame  = frame;
            st_d.idx    = '0;
            st_d.active = !skip;
            st_d.done   = skip;
        end else if (st_q.active && wr_ready) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid = st_q.active;
    assign wr_addr  = st_q.base + (DW'(st_q.idx) << BYTE_SHIFT);
    assign wr_data  = st_q.frame[st_q.idx*DW +: DW];
    assign done     = st_q.done;

endmodule

// File: rtl/exc_vector_reader.sv
`timescale 1ns/1ps
module exc_vector_reader #(
    parameter int unsigned NUM_W = 8,
    parameter int unsigned DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DW-1:0]    table_base,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_addr,
    input  logic             rd_ready,
    input  logic [DW-1:0]    rd_data,
    output logic             done,
    output logic [DW-1:0]    vector
);

    localparam int unsigned BYTE_SHIFT = $clog2(DW / 8);

    typedef struct packed {
        logic          pend;
        logic          done;
        logic [DW-1:0] addr;
        logic [DW-1:0] vec;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            // a restart drops whatever the previous request returns this cycle
            st_d.pend = 1'b1;
            st_d.done = 1'b0;
            st_d.addr = table_base + (DW'(num) << BYTE_SHIFT);
        end else if (st_q.pend && rd_ready) begin
            st_d.pend = 1'b0;
            st_d.done = 1'b1;
            st_d.vec  = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.pend;
    assign rd_addr  = st_q.addr;
    assign done     = st_q.done;
    assign vector   = st_q.vec;

endmodule

// File: rtl/exc_entry_seq.sv
`timescale 1ns/1ps
module exc_entry_seq #(
    parameter int unsigned NUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_valid,
    input  logic [NUM_W-1:0] grant_num,
    input  logic             grant_tail,
    input  logic             from_handler,
    input  logic             on_psp,
    input  logic [31:0]      cur_sp,
    input  logic [255:0]     ctx_frame,
    input  logic [31:0]      vec_base,
    input  logic             late_valid,
    input  logic [NUM_W-1:0] late_num,
    output logic             busy,
    output logic             wr_valid,
    output logic [31:0]      wr_addr,
    output logic [31:0]      wr_data,
    input  logic             wr_ready,
    output logic             rd_valid,
    output logic [31:0]      rd_addr,
    input  logic             rd_ready,
    input  logic [31:0]      rd_data,
    output logic             done_valid,
    output logic [31:0]      done_handler,
    output logic [NUM_W-1:0] done_num,
    output logic [31:0]      done_lr,
    output logic             sp_load,
    output logic [31:0]      sp_value
);

    import exc_entry_pkg::*;

    typedef struct packed {
        entry_state_e      state;
        logic [NUM_W-1:0]  num;
        logic [WORD_W-1:0] code;
        logic [WORD_W-1:0] sp_new;
        logic              stacked;
        logic              out_valid;
        logic [WORD_W-1:0] out_handler;
        logic [NUM_W-1:0]  out_num;
        logic [WORD_W-1:0] out_lr;
        logic              out_sp_load;
        logic [WORD_W-1:0] out_sp;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic             wr_start;
    logic             rd_start;
    logic [NUM_W-1:0] rd_num;
    logic             frame_done;
    logic             vec_done;
    logic [31:0]      vec_word;

    always_comb begin
        st_d             = st_q;
        st_d.out_valid   = 1'b0;
        st_d.out_sp_load = 1'b0;
        wr_start         = 1'b0;
        rd_start         = 1'b0;
        rd_num           = grant_num;
        unique case (st_q.state)
            ENTRY_IDLE: begin
                if (grant_valid) begin
                    st_d.state   = ENTRY_RUN;
                    st_d.num     = grant_num;
                    st_d.code    = return_code(from_handler, on_psp);
                    st_d.sp_new  = cur_sp - WORD_W'(FRAME_BYTES);
                    st_d.stacked = !grant_tail;
                    wr_start     = 1'b1;
                    rd_start     = 1'b1;
                end
            end
            ENTRY_RUN: begin
                if (late_valid) begin
                    st_d.num = late_num;
                    rd_start = 1'b1;
                    rd_num   = late_num;
                end else if (frame_done && vec_done) begin
                    st_d.state       = ENTRY_IDLE;
                    st_d.out_valid   = 1'b1;
                    st_d.out_handler = vec_word;
                    st_d.out_num     = st_q.num;
                    st_d.out_lr      = st_q.code;
                    st_d.out_sp_load = st_q.stacked;
                    st_d.out_sp      = st_q.sp_new;
                end
            end
            default: st_d.state = ENTRY_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    exc_frame_writer #(
        .WORDS (FRAME_WORDS),
        .DW    (WORD_W)
    ) u_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (wr_start),
        .skip     (grant_tail),
        .base     (st_d.sp_new),
        .frame    (ctx_frame),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .done     (frame_done)
    );

    exc_vector_reader #(
        .NUM_W (NUM_W),
        .DW    (WORD_W)
    ) u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (rd_start),
        .num        (rd_num),
        .table_base (vec_base),
        .rd_valid   (rd_valid),
        .rd_addr    (rd_addr),
        .rd_ready   (rd_ready),
        .rd_data    (rd_data),
        .done       (vec_done),
        .vector     (vec_word)
    );

    assign busy         = (st_q.state == ENTRY_RUN);
    assign done_valid   = st_q.out_valid;
    assign done_handler = st_q.out_handler;
    assign done_num     = st_q.out_num;
    assign done_lr      = st_q.out_lr;
    assign sp_load      = st_q.out_sp_load;
    assign sp_value     = st_q.out_sp;

endmodule

// File: rtl/exc_entry_seq_chk.sv
`timescale 1ns/1ps
module exc_entry_seq_chk #(
    parameter int unsigned NUM_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             grant_valid,
    input logic             grant_tail,
    input logic [31:0]      cur_sp,
    input logic [31:0]      vec_base,
    input logic             late_valid,
    input logic [NUM_W-1:0] late_num,
    input logic             busy,
    input logic             wr_valid,
    input logic [31:0]      wr_addr,
    input logic [31:0]      wr_data,
    input logic             wr_ready,
    input logic             rd_valid,
    input logic [31:0]      rd_addr,
    input logic             rd_ready,
    input logic             done_valid,
    input logic [31:0]      done_lr,
    input logic             sp_load,
    input logic [31:0]      sp_value
);

    logic [2:0]  wcnt_q;
    logic        tail_q;
    logic [31:0] sp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            tail_q <= 1'b0;
            sp_q   <= '0;
        end else if (grant_valid && !busy) begin
            wcnt_q <= '0;
            tail_q <= grant_tail;
            sp_q   <= cur_sp - 32'd32;
        end else if (wr_valid && wr_ready) begin
            wcnt_q <= wcnt_q + 3'd1;
        end
    end

    // R2: consecutive frame words go to consecutive rising addresses
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wcnt_q != 3'd7) |=> (wr_valid && wr_addr == $past(wr_addr) + 32'd4));

    // R3: a stalled write holds address and data
    a_r3_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R3: a stalled read holds its address unless restarted by a late arrival
    a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !(busy && late_valid)) |=> (rd_valid && $stable(rd_addr)));

    // R5: the handler never starts while a frame write is still outstanding
    a_r5_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (!wr_valid && !rd_valid));

    // R6: a stacked entry loads the frame base as the new stack pointer
    a_r6_sp_value: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && sp_load) |-> (sp_value == sp_q));

    // R7: tail-chained entries never write
    a_r7_tail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tail_q) |-> !wr_valid);

    // R8: return code is one of the three legal values
    a_r8_lr_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_lr == 32'hFFFF_FFF1 || done_lr == 32'hFFFF_FFF9 || done_lr == 32'hFFFF_FFFD));

    // R10: a late arrival reissues the vector read for the new number
    a_r10_late_reissue: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && late_valid) |=> (rd_valid && rd_addr == $past(vec_base) + ({{(32-NUM_W){1'b0}}, $past(late_num)} << 2)));

    // R11: late arrival while idle starts nothing
    a_r11_idle_late: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !grant_valid && late_valid) |=> !rd_valid);

    // R12: the completion pulse lasts one cycle and ends the busy phase
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    a_r1_busy_falls: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_valid) |-> $fell(busy));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.NUM_W(NUM_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_valid (grant_valid),
    .grant_tail  (grant_tail),
    .cur_sp      (cur_sp),
    .vec_base    (vec_base),
    .late_valid  (late_valid),
    .late_num    (late_num),
    .busy        (busy),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_ready    (wr_ready),
    .rd_valid    (rd_valid),
    .rd_addr     (rd_addr),
    .rd_ready    (rd_ready),
    .done_valid  (done_valid),
    .done_lr     (done_lr),
    .sp_load     (sp_load),
    .sp_value    (sp_value)
);

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;

    localparam int unsigned NUM_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             grant_valid = 1'b0;
    logic [NUM_W-1:0] grant_num = '0;
    logic             grant_tail = 1'b0;
    logic             from_handler = 1'b0;
    logic             on_psp = 1'b0;
    logic [31:0]      cur_sp = '0;
    logic [255:0]     ctx_frame = '0;
    logic [31:0]      vec_base = 32'h0000_4000;
    logic             late_valid = 1'b0;
    logic [NUM_W-1:0] late_num = '0;
    logic             busy, wr_valid, rd_valid, done_valid, sp_load;
    logic [31:0]      wr_addr, wr_data, rd_addr, rd_data, done_handler, done_lr, sp_value;
    logic [NUM_W-1:0] done_num;
    logic             wr_ready = 1'b1;
    logic             rd_ready = 1'b1;

    typedef struct packed {
        logic [31:0]      handler;
        logic [31:0]      lr;
        logic [NUM_W-1:0] num;
        logic             sp_load;
        logic [31:0]      sp;
        logic [7:0]       lat;
    } done_item_t;

    logic [63:0] exp_wr[$];
    done_item_t  exp_done[$];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int grant_cyc = 0;
    logic stall_mode = 1'b0;
    logic finished = 1'b0;

    exc_entry_seq #(.NUM_W(NUM_W)) i_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .grant_valid(grant_valid), .grant_num(grant_num),
        .grant_tail(grant_tail), .from_handler(from_handler), .on_psp(on_psp),
        .cur_sp(cur_sp), .ctx_frame(ctx_frame), .vec_base(vec_base),
        .late_valid(late_valid), .late_num(late_num), .busy(busy),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .done_valid(done_valid), .done_handler(done_handler), .done_num(done_num),
        .done_lr(done_lr), .sp_load(sp_load), .sp_value(sp_value)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] vec_mem(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h0F0F_0001;
    endfunction

    assign rd_data = vec_mem(rd_addr);

    always @(posedge clk) cyc <= cyc + 1;

    // port readiness: always ready, or a fixed stall pattern
    initial begin
        forever begin
            @(posedge clk);
            #1;
            wr_ready = stall_mode ? ((cyc % 3) != 1) : 1'b1;
            rd_ready = stall_mode ? ((cyc % 4) == 0) : 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compare produced results against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid && wr_ready) begin
                if (exp_wr.size() == 0) begin
                    check(1'b0, "R7 unexpected write", {wr_addr, wr_data}, 64'h0);
                end else begin
                    logic [63:0] e;
                    e = exp_wr.pop_front();
                    check({wr_addr, wr_data} == e, "R2 frame write", {wr_addr, wr_data}, e);
                end
            end
            if (done_valid) begin
                if (exp_done.size() == 0) begin
                    check(1'b0, "R12 unexpected done", 64'(done_num), 64'h0);
                end else begin
                    done_item_t e;
                    e = exp_done.pop_front();
                    check(done_handler == e.handler, "R5 handler address", 64'(done_handler), 64'(e.handler));
                    check(done_lr == e.lr, "R8 return code", 64'(done_lr), 64'(e.lr));
                    check(done_num == e.num, "R9/R10 activated number", 64'(done_num), 64'(e.num));
                    check(sp_load == e.sp_load, "R6 sp_load", 64'(sp_load), 64'(e.sp_load));
                    if (e.sp_load)
                        check(sp_value == e.sp, "R6 sp_value", 64'(sp_value), 64'(e.sp));
                    if (e.lat != 0)
                        check((cyc - grant_cyc) == int'(e.lat), "R12 latency", 64'(cyc - grant_cyc), 64'(e.lat));
                end
            end
        end
    end

    task automatic run_entry(input logic [NUM_W-1:0] num, input bit tail, input bit fh,
                             input bit psp, input logic [31:0] sp, input int late_k,
                             input logic [NUM_W-1:0] lnum, input int lat);
        logic [255:0] frame;
        done_item_t   it;
        logic [NUM_W-1:0] eff;
        for (int i = 0; i < 8; i++) frame[32*i +: 32] = {sp[15:0], 8'(num), 8'(i)};
        eff = (late_k > 0) ? lnum : num;
        if (!tail)
            for (int i = 0; i < 8; i++)
                exp_wr.push_back({sp - 32'd32 + 32'(4 * i), frame[32*i +: 32]});
        it.handler = vec_mem(vec_base + {24'h0, eff, 2'b00} >> 0);
        it.handler = vec_mem(vec_base + (32'(eff) << 2));
        it.lr      = fh ? 32'hFFFF_FFF1 : (psp ? 32'hFFFF_FFFD : 32'hFFFF_FFF9);
        it.num     = eff;
        it.sp_load = !tail;
        it.sp      = sp - 32'd32;
        it.lat     = 8'(lat);
        exp_done.push_back(it);

        @(posedge clk); #1;
        grant_valid  = 1'b1; grant_num = num; grant_tail = tail;
        from_handler = fh; on_psp = psp; cur_sp = sp; ctx_frame = frame;
        grant_cyc    = cyc;
        @(posedge clk); #1;
        grant_valid = 1'b0;
        ctx_frame   = ~frame;          // R2: captured on the grant edge
        cur_sp      = 32'hDEAD_0000;
        from_handler = ~fh; on_psp = ~psp;
        @(negedge clk);
        check(busy == 1'b1, "R1 busy after grant", 64'(busy), 64'h1);
        check(rd_valid == 1'b1, "R4 vector read issued", 64'(rd_valid), 64'h1);
        check(rd_addr == vec_base + (32'(num) << 2), "R4 vector address", 64'(rd_addr),
              64'(vec_base + (32'(num) << 2)));
        if (late_k > 0) begin
            while (cyc < grant_cyc + late_k) begin @(posedge clk); #1; end
            late_valid = 1'b1; late_num = lnum;
            @(posedge clk); #1;
            late_valid = 1'b0;
        end
        do @(negedge clk); while (busy);
        @(negedge clk);
        check(exp_wr.size() == 0, "R2/R7 write count", 64'(exp_wr.size()), 64'h0);
        check(exp_done.size() == 0, "R5 completion seen", 64'(exp_done.size()), 64'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R1 reset busy", 64'(busy), 64'h0);
        check(wr_valid == 1'b0, "R2 reset wr_valid", 64'(wr_valid), 64'h0);
        check(rd_valid == 1'b0, "R4 reset rd_valid", 64'(rd_valid), 64'h0);
        check(done_valid == 1'b0, "R12 reset done", 64'(done_valid), 64'h0);
        #1 rst_n = 1'b1;

        run_entry(8'd15, 1'b0, 1'b0, 1'b0, 32'h2000_1000, 0, 8'd0, 10); // R2 R6 R8 R12
        stall_mode = 1'b1;
        run_entry(8'd3,  1'b0, 1'b0, 1'b1, 32'h2000_0F00, 0, 8'd0, 0);  // R3 with stalls
        stall_mode = 1'b0;
        run_entry(8'd40, 1'b0, 1'b1, 1'b0, 32'h2000_0800, 3, 8'd50, 10); // R10 early late
        run_entry(8'd7,  1'b1, 1'b1, 1'b0, 32'h2000_0700, 0, 8'd0, 3);   // R7 tail
        run_entry(8'd9,  1'b1, 1'b0, 1'b1, 32'h2000_0600, 1, 8'd2, 4);   // R10 late in tail
        run_entry(8'd20, 1'b0, 1'b0, 1'b1, 32'h2000_0500, 8, 8'd60, 11); // R10 late at last write
        stall_mode = 1'b1;
        run_entry(8'd33, 1'b0, 1'b1, 1'b1, 32'h2000_0400, 2, 8'd1, 0);  // R10 with stalls
        stall_mode = 1'b0;

        // R11: late arrival while idle
        @(posedge clk); #1;
        late_valid = 1'b1; late_num = 8'd77;
        @(posedge clk); #1;
        late_valid = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R11 idle late busy", 64'(busy), 64'h0);
        check(rd_valid == 1'b0, "R11 idle late read", 64'(rd_valid), 64'h0);
        check(done_valid == 1'b0, "R11 idle late done", 64'(done_valid), 64'h0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule